// File: doc/BRIEF.md
# SRAM Bus Cycle Timing Generator

This block runs one read or one write at a time on an asynchronous SRAM-style external bus. An internal master raises a request with a direction, an area number, an address and write data. The block then drives the address, the chip select of the chosen area, a read or write strobe and a data-drive enable through a fixed sequence of phases. The sequence is an optional setup cycle, a strobe phase, an optional read-strobe extension and a run of hold cycles. A one-clock acknowledge closes the access.

Every area has its own 4-bit timing field, a 2-bit area type and a 3-bit strobe width. The settings are taken from the chosen area when the request is accepted. On a read, the hold cycles follow the data sampling point. On a write, they follow the negation of the write strobe. Two areas can keep the read strobe asserted for one extra cycle after sampling.

Top module: `sram_cycle_gen`

## Requirements
- R1: After reset and while idle, every chip select and both strobes are high (inactive), and `bus_oe` and `ack` are low.
- R2: Area n's timing field sits at `timing_cfg[4n+3:4n]`. Bit 4n+2 is the setup bit: when it is 1, one cycle with chip select and address active and no strobe comes before the strobe; when it is 0, the strobe is active in the first cycle of the access.
- R3: The strobe stays asserted for `access_wait[3n+2:3n]` + 1 cycles. Read data on `bus_din` is captured at the clock edge that ends the last of those cycles and is held on `rdata`.
- R4: After a write strobe is negated, the block adds the number of hold cycles in bits 4n+1:4n (0 to 3). During these cycles it keeps chip select, address, `bus_dout` and `bus_oe` driven. `bus_oe` is high in every cycle of a write and low in every cycle of a read.
- R5: On a read, the hold cycles (bits 4n+1:4n) are counted from the sampling edge, with the read strobe negated during them.
- R6: Bit 4n+3 (read-strobe extension) takes effect only for the areas selected by `RDH_AREAS` (default areas 1 and 4), only for area type SRAM, and only on reads. When it takes effect, the read strobe stays asserted for one extra cycle after sampling and the hold cycles follow that cycle. Everywhere else the bit has no effect.
- R7: An area of type byte-control SRAM (code 1) treats its read-strobe extension bit as 0.
- R8: The area type is `area_type[2n+1:2n]`, with the codes 0 SRAM, 1 byte-control SRAM, 2 burst ROM and 3 other. For type 3, the setup bit and the hold count are ignored and treated as 0.
- R9: Only the chip select of the accessed area is asserted. It stays low from the first cycle to the last cycle of the access. `ack` is high for exactly that last cycle, so an access lasts setup + wait + 1 + extension + hold cycles.
- R10: A request is accepted only while the block is idle. Changes to the area settings or to `req` during an access do not affect that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_area | input | 3 | Area number |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| timing_cfg | input | 28 | Packed 4-bit timing field per area |
| area_type | input | 14 | Packed 2-bit type per area |
| access_wait | input | 21 | Packed 3-bit strobe wait per area |
| bus_addr | output | 16 | External address |
| bus_cs_n | output | 7 | Active-low chip select per area |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_oe | output | 1 | Data-bus drive enable |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |

## Verification
The request is taken at the first rising edge after `req` goes high. Cycle 1 of the access is the clock period after that edge, and every phase output is a decode of the registered state, so it is valid throughout its cycle. The bench samples on falling edges and numbers the cycles from 1. It expects the first strobe cycle at setup + 1, the acknowledge and the last chip-select cycle at the full cycle count, and chip select high again in the cycle after. The bench changes `bus_din` to a value tagged with the cycle index at each falling edge, so `rdata` shows which edge captured it. The expected capture is cycle setup + wait + 1, checked once the access has ended.

// File: rtl/sram_tg_pkg.sv
package sram_tg_pkg;

   typedef enum logic [1:0] {
      AT_SRAM  = 2'd0,
      AT_BSRAM = 2'd1,
      AT_BROM  = 2'd2,
      AT_OTHER = 2'd3
   } area_type_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STRB,
      ST_RDH,
      ST_HOLD
   } seq_state_e;

   // one area's timing nibble, msb first
   typedef struct packed {
      logic       rdh;
      logic       setup;
      logic [1:0] hold;
   } tfield_t;

endpackage

// File: rtl/sram_tg_cfg_sel.sv
module sram_tg_cfg_sel
   import sram_tg_pkg::*;
#(
   parameter int NUM_AREAS = 7,
   parameter int WAIT_W    = 3,
   parameter int AREA_W    = 3,
   parameter logic [15:0] RDH_AREAS = 16'h0012
) (
   input  logic [4*NUM_AREAS-1:0]      timing_cfg,
   input  logic [2*NUM_AREAS-1:0]      area_type,
   input  logic [WAIT_W*NUM_AREAS-1:0] access_wait,
   input  logic [AREA_W-1:0]           sel_area,
   output tfield_t                     eff,
   output logic [WAIT_W-1:0]           wait_cyc
);

   tfield_t           eff_arr  [NUM_AREAS];
   logic [WAIT_W-1:0] wait_arr [NUM_AREAS];

   for (genvar n = 0; n < NUM_AREAS; n++) begin : g_area
      tfield_t    raw;
      area_type_e typ;
      logic       timed;
      assign raw   = timing_cfg[4*n +: 4];
      assign typ   = area_type_e'(area_type[2*n +: 2]);
      assign timed = (typ != AT_OTHER);
      assign eff_arr[n].setup = timed & raw.setup;
      assign eff_arr[n].hold  = timed ? raw.hold : 2'd0;
      if (RDH_AREAS[n]) begin : g_rdh
         assign eff_arr[n].rdh = raw.rdh & (typ == AT_SRAM);
      end else begin : g_nordh
         assign eff_arr[n].rdh = 1'b0;
      end
      assign wait_arr[n] = access_wait[WAIT_W*n +: WAIT_W];
   end

   always_comb begin
      eff      = '0;
      wait_cyc = '0;
      for (int n = 0; n < NUM_AREAS; n++) begin
         if (sel_area == AREA_W'(n)) begin
            eff      = eff_arr[n];
            wait_cyc = wait_arr[n];
         end
      end
   end

endmodule

// File: rtl/sram_tg_seq.sv
module sram_tg_seq
   import sram_tg_pkg::*;
#(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  tfield_t           eff,
   input  logic [WAIT_W-1:0] wait_cyc,
   output logic              idle,
   output logic              wr,
   output logic              rd_strb,
   output logic              wr_strb,
   output logic              sample,
   output logic              last
);

   localparam int CNT_W = (WAIT_W > 2) ? WAIT_W : 2;

   seq_state_e       st, st_d;
   logic [CNT_W-1:0] cnt, cnt_d;
   logic [1:0]       hold_q;
   logic             rdh_q;
   logic             wr_q;
   logic             accept;

   assign accept = (st == ST_IDLE) && req;

   always_comb begin
      st_d  = st;
      cnt_d = cnt;
      case (st)
         ST_IDLE: begin
            if (req) begin
               st_d  = eff.setup ? ST_SETUP : ST_STRB;
               cnt_d = CNT_W'(wait_cyc);
            end
         end
         ST_SETUP: st_d = ST_STRB;
         ST_STRB: begin
            if (cnt != '0) begin
               cnt_d = cnt - CNT_W'(1);
            end else if (rdh_q) begin
               st_d = ST_RDH;
            end else if (hold_q != 2'd0) begin
               st_d  = ST_HOLD;
               cnt_d = CNT_W'(hold_q) - CNT_W'(1);
            end else begin
               st_d = ST_IDLE;
            end
         end
         ST_RDH: begin
            if (hold_q != 2'd0) begin
               st_d  = ST_HOLD;
               cnt_d = CNT_W'(hold_q) - CNT_W'(1);
            end else begin
               st_d = ST_IDLE;
            end
         end
         ST_HOLD: begin
            if (cnt != '0) cnt_d = cnt - CNT_W'(1);
            else           st_d  = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         hold_q <= 2'd0;
         rdh_q  <= 1'b0;
         wr_q   <= 1'b0;
      end else begin
         st  <= st_d;
         cnt <= cnt_d;
         if (accept) begin
            wr_q   <= req_we;
            hold_q <= eff.hold;
            rdh_q  <= eff.rdh & ~req_we;
         end
      end
   end

   assign idle    = (st == ST_IDLE);
   assign wr      = wr_q;
   assign rd_strb = !wr_q && ((st == ST_STRB) || (st == ST_RDH));
   assign wr_strb = wr_q && (st == ST_STRB);
   assign sample  = (st == ST_STRB) && (cnt == '0);
   assign last    = ((st == ST_STRB) && (cnt == '0) && !rdh_q && (hold_q == 2'd0))
                 || ((st == ST_RDH) && (hold_q == 2'd0))
                 || ((st == ST_HOLD) && (cnt == '0));

endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
   import sram_tg_pkg::*;
#(
   parameter int NUM_AREAS = 7,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int WAIT_W    = 3,
   parameter logic [15:0] RDH_AREAS = 16'h0012,
   localparam int AREA_W   = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req,
   input  logic                        req_we,
   input  logic [AREA_W-1:0]           req_area,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   output logic                        ack,
   output logic [DATA_W-1:0]           rdata,
   input  logic [4*NUM_AREAS-1:0]      timing_cfg,
   input  logic [2*NUM_AREAS-1:0]      area_type,
   input  logic [WAIT_W*NUM_AREAS-1:0] access_wait,
   output logic [ADDR_W-1:0]           bus_addr,
   output logic [NUM_AREAS-1:0]        bus_cs_n,
   output logic                        bus_rd_n,
   output logic                        bus_we_n,
   output logic                        bus_oe,
   output logic [DATA_W-1:0]           bus_dout,
   input  logic [DATA_W-1:0]           bus_din
);

   if (NUM_AREAS < 1 || NUM_AREAS > 16) begin : g_bad_areas
      $error("NUM_AREAS must lie in 1..16");
   end
   if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait
      $error("WAIT_W must lie in 1..8");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
      $error("ADDR_W and DATA_W must be positive");
   end

   tfield_t           eff;
   logic [WAIT_W-1:0] wait_cyc;
   logic              idle, wr, rd_strb, wr_strb, sample, last;
   logic              accept;
   logic [AREA_W-1:0] area_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   sram_tg_cfg_sel #(
      .NUM_AREAS (NUM_AREAS),
      .WAIT_W    (WAIT_W),
      .AREA_W    (AREA_W),
      .RDH_AREAS (RDH_AREAS)
   ) u_cfg (
      .timing_cfg  (timing_cfg),
      .area_type   (area_type),
      .access_wait (access_wait),
      .sel_area    (req_area),
      .eff         (eff),
      .wait_cyc    (wait_cyc)
   );

   sram_tg_seq #(
      .WAIT_W (WAIT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_we   (req_we),
      .eff      (eff),
      .wait_cyc (wait_cyc),
      .idle     (idle),
      .wr       (wr),
      .rd_strb  (rd_strb),
      .wr_strb  (wr_strb),
      .sample   (sample),
      .last     (last)
   );

   assign accept = idle && req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         area_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         if (accept) begin
            area_q  <= req_area;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (sample && !wr) rdata <= bus_din;
      end
   end

   for (genvar n = 0; n < NUM_AREAS; n++) begin : g_cs
      assign bus_cs_n[n] = !(!idle && (area_q == AREA_W'(n)));
   end

   assign bus_addr = addr_q;
   assign bus_dout = wdata_q;
   assign bus_oe   = !idle && wr;
   assign bus_rd_n = !rd_strb;
   assign bus_we_n = !wr_strb;
   assign ack      = last;

endmodule

// File: rtl/sram_tg_chk.sv
module sram_tg_chk #(
   parameter int NUM_AREAS = 7,
   parameter int ADDR_W    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ack,
   input logic [NUM_AREAS-1:0] bus_cs_n,
   input logic                 bus_rd_n,
   input logic                 bus_we_n,
   input logic                 bus_oe,
   input logic [ADDR_W-1:0]    bus_addr
);

   logic cs_act;
   assign cs_act = !(&bus_cs_n);

   // R9: at most one area selected
   a_r9_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));

   // R9: strobes only inside a selected access
   a_r9_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_we_n) |-> cs_act);

   // R3: never both strobes together
   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_we_n));

   // R9: ack is one clock and ends the access
   a_r9_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (!ack && !cs_act));

   // R9: ack only during a selected access
   a_r9_ack_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> cs_act);

   // R4: write strobe only with data driven
   a_r4_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> bus_oe);

   // R4: no data drive while deselected
   a_r4_oe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> cs_act);

   // R10: address held across an access
   a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && $past(cs_act)) |-> $stable(bus_addr));

   // R4: read and write direction does not flip inside an access
   a_r4_oe_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && $past(cs_act)) |-> $stable(bus_oe));

endmodule

bind sram_cycle_gen sram_tg_chk #(
   .NUM_AREAS (NUM_AREAS),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack      (ack),
   .bus_cs_n (bus_cs_n),
   .bus_rd_n (bus_rd_n),
   .bus_we_n (bus_we_n),
   .bus_oe   (bus_oe),
   .bus_addr (bus_addr)
);

// File: tb/sram_cycle_gen_tb.sv
module sram_cycle_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NA = 7;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int WW = 3;
   localparam logic [DW-1:0] DIN_BASE = 16'hA000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req = 1'b0;
   logic            req_we = 1'b0;
   logic [2:0]      req_area = '0;
   logic [AW-1:0]   req_addr = '0;
   logic [DW-1:0]   req_wdata = '0;
   logic            ack;
   logic [DW-1:0]   rdata;
   logic [4*NA-1:0] timing_cfg = '0;
   logic [2*NA-1:0] area_type = '0;
   logic [WW*NA-1:0] access_wait = '0;
   logic [AW-1:0]   bus_addr;
   logic [NA-1:0]   bus_cs_n;
   logic            bus_rd_n, bus_we_n, bus_oe;
   logic [DW-1:0]   bus_dout;
   logic [DW-1:0]   bus_din = '0;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_cycle_gen u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (req),
      .req_we      (req_we),
      .req_area    (req_area),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .ack         (ack),
      .rdata       (rdata),
      .timing_cfg  (timing_cfg),
      .area_type   (area_type),
      .access_wait (access_wait),
      .bus_addr    (bus_addr),
      .bus_cs_n    (bus_cs_n),
      .bus_rd_n    (bus_rd_n),
      .bus_we_n    (bus_we_n),
      .bus_oe      (bus_oe),
      .bus_dout    (bus_dout),
      .bus_din     (bus_din)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic set_area(input int n, input bit rdh, input bit setup, input int hold,
                           input int typ, input int wt);
      timing_cfg[4*n +: 4]    = {rdh, setup, 2'(hold)};
      area_type[2*n +: 2]     = 2'(typ);
      access_wait[WW*n +: WW] = WW'(wt);
   endtask

   // One access, cycles numbered from 1 after the accepting edge.
   task automatic run_access(input string rq, input bit we, input int area,
                             input int s, input int w, input int h, input int rdh,
                             input bit disturb);
      logic [AW-1:0]    a;
      logic [DW-1:0]    d;
      logic [4*NA-1:0]  sv_cfg;
      logic [2*NA-1:0]  sv_typ;
      logic [WW*NA-1:0] sv_wait;
      int n_cs, first_strb, n_strb, ack_at, n_ack, bad_sel, bad_addr, bad_drv, n_exp, ext;
      n_cs = 0; first_strb = 0; n_strb = 0; ack_at = 0; n_ack = 0;
      bad_sel = 0; bad_addr = 0; bad_drv = 0;
      ext = we ? 0 : rdh;
      n_exp = s + w + 1 + ext + h;
      a = AW'(16'h1200 + area * 16'h31 + w * 7 + h);
      d = DW'(16'h5A00 + area * 16'h13 + s);
      sv_cfg = timing_cfg; sv_typ = area_type; sv_wait = access_wait;
      @(negedge clk);
      req = 1'b1; req_we = we; req_area = 3'(area); req_addr = a; req_wdata = d;
      @(posedge clk);
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (&bus_cs_n) break;
         n_cs++;
         if (bus_cs_n !== ~(NA'(1) << area)) bad_sel++;
         if (bus_addr !== a) bad_addr++;
         if (bus_oe !== we || (we && bus_dout !== d)) bad_drv++;
         if (we ? !bus_we_n : !bus_rd_n) begin
            if (first_strb == 0) first_strb = i;
            n_strb++;
         end
         if (ack) begin
            n_ack++;
            if (ack_at == 0) ack_at = i;
            req = 1'b0;
         end
         if (disturb && i == 1) begin
            // R10: settings flipped and req held during the access
            timing_cfg  = ~timing_cfg;
            area_type   = ~area_type;
            access_wait = ~access_wait;
            req_area    = ~req_area;
         end
         bus_din = DIN_BASE + DW'(i);
      end
      req = 1'b0;
      if (disturb) begin
         timing_cfg = sv_cfg; area_type = sv_typ; access_wait = sv_wait;
      end
      chk("R9", {rq, " chip-select cycles"}, n_cs, n_exp);
      chk("R9", {rq, " ack cycle"}, ack_at, n_exp);
      chk("R9", {rq, " ack count"}, n_ack, 1);
      chk("R9", {rq, " wrong chip-select cycles"}, bad_sel, 0);
      chk(rq, "first strobe cycle", first_strb, s + 1);
      chk(rq, "strobe cycles", n_strb, w + 1 + ext);
      chk(rq, "address/data drive errors", bad_addr + bad_drv, 0);
      if (!we) chk(rq, "read data sample", int'(rdata), int'(DIN_BASE + DW'(s + w + 1)));
   endtask

   // R1: reset state
   task automatic t_reset();
      @(negedge clk);
      chk("R1", "cs_n idle", int'(bus_cs_n), int'({NA{1'b1}}));
      chk("R1", "rd_n/we_n idle", int'({bus_rd_n, bus_we_n}), 3);
      chk("R1", "oe/ack idle", int'({bus_oe, ack}), 0);
   endtask

   // R2 R3: no setup, single-cycle strobe write
   task automatic t_plain_write();
      set_area(0, 1'b0, 1'b0, 0, 0, 0);
      run_access("R2", 1'b1, 0, 0, 0, 0, 0, 1'b0);
   endtask

   // R4: write with setup, long strobe, maximum hold
   task automatic t_write_hold();
      set_area(2, 1'b0, 1'b1, 3, 0, 2);
      run_access("R4", 1'b1, 2, 1, 2, 3, 0, 1'b0);
   endtask

   // R5 R3: read hold after the sampling point
   task automatic t_read_hold();
      set_area(3, 1'b0, 1'b1, 2, 0, 1);
      run_access("R5", 1'b0, 3, 1, 1, 2, 0, 1'b0);
      set_area(3, 1'b0, 1'b0, 0, 0, 7);
      run_access("R3", 1'b0, 3, 0, 7, 0, 0, 1'b0);
   endtask

   // R6: read-strobe extension on areas 1 and 4, ignored elsewhere and on writes
   task automatic t_rdh();
      set_area(1, 1'b1, 1'b0, 1, 0, 0);
      run_access("R6", 1'b0, 1, 0, 0, 1, 1, 1'b0);
      set_area(4, 1'b1, 1'b1, 0, 0, 1);
      run_access("R6", 1'b0, 4, 1, 1, 0, 1, 1'b0);
      set_area(4, 1'b1, 1'b0, 1, 0, 1);
      run_access("R6", 1'b1, 4, 0, 1, 1, 1, 1'b0);
      set_area(0, 1'b1, 1'b0, 0, 0, 0);
      run_access("R6", 1'b0, 0, 0, 0, 0, 0, 1'b0);
   endtask

   // R7: byte-control SRAM clears the extension
   task automatic t_byte_mode();
      set_area(1, 1'b1, 1'b0, 0, 1, 1);
      run_access("R7", 1'b0, 1, 0, 1, 0, 0, 1'b0);
   endtask

   // R8: type other drops setup and hold; burst ROM keeps them
   task automatic t_area_types();
      set_area(5, 1'b0, 1'b1, 3, 3, 2);
      run_access("R8", 1'b0, 5, 0, 2, 0, 0, 1'b0);
      set_area(6, 1'b0, 1'b1, 1, 2, 0);
      run_access("R8", 1'b0, 6, 1, 0, 1, 0, 1'b0);
   endtask

   // R10: settings latched at accept; held req not re-accepted
   task automatic t_latch();
      set_area(2, 1'b0, 1'b1, 2, 0, 3);
      run_access("R10", 1'b1, 2, 1, 3, 2, 0, 1'b1);
      @(negedge clk);
      chk("R10", "idle after held request", int'(bus_cs_n), int'({NA{1'b1}}));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain_write();
      t_write_hold();
      t_read_hold();
      t_rdh();
      t_byte_mode();
      t_area_types();
      t_latch();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule